// File: doc/BRIEF.md
# Trigger Look-Back Sample Pipeline

This block is the digital control of a multi-channel front-end sample pipeline. On every clock it stores one column of channel samples into a circular buffer. The buffer keeps a fixed history. A trigger then selects the column captured a fixed latency earlier. In multi-sample mode it also selects the two columns captured after that one. The selected columns are sent out serially as framed data, one channel word per clock.

Triggers that arrive while a readout is in progress wait in a small queue. The `busy` output gives backpressure to the trigger source. A trigger that finds the queue full is dropped and raises a sticky overflow flag. Columns waiting for readout are protected: the write pointer skips over them, so history that is still needed is never overwritten.

Top module: `lookback_pipe`

## Requirements
- R1: In 1-sample mode, an accepted trigger sampled at clock edge t reads out the column captured at edge t-160. Each channel word equals the sample that channel held at that edge.
- R2: With `three` high at the trigger, three frames follow in order. They carry the columns captured at edges t-160, t-159 and t-158.
- R3: A frame lasts 141 clocks. Words 0 to 10 are all-ones markers. Word 11 is the ring slot of the column, zero-extended. Words 12 to 139 are channels 0 to 127 in that order. Word 140 is idle, with `fv` low and `dout` zero. `fv` is high for exactly the first 140 clocks. With no earlier locks since reset, the column captured at edge k sits in slot k mod 192.
- R4: When nothing else is pending, `busy` rises in the cycle after an accepted trigger. It stays high for 141·N+1 cycles, where N is the number of columns read.
- R5: Triggers accepted during a readout are served in arrival order. Their frames follow with no gap other than the idle word, and `busy` stays high between them.
- R6: At most 4 triggers wait behind the active readout. A trigger that arrives while 4 are waiting is dropped and sets `ovf`. `ovf` stays set until reset.
- R7: A column selected for readout is never overwritten before it has been read, however long the queue takes to drain.
- R8: Reset clears the pointers, the queue, `busy`, `fv` and `ovf`. Triggers are ignored until 160 columns have been captured after reset. A trigger at edge 159 is ignored, and one at edge 160 reads the first column captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samples | input | NCH*SW | One sample per channel; channel c occupies bits c*SW+SW-1 down to c*SW |
| trig | input | 1 | Trigger pulse, one clock |
| three | input | 1 | Sampled with the trigger: 1 selects three columns, 0 selects one |
| dout | output | SW | Serial frame word |
| fv | output | 1 | Frame word valid |
| busy | output | 1 | Readout active or triggers pending |
| ovf | output | 1 | Sticky trigger-drop flag |

## Verification
A wrong look-back pointer or a broken lock shows as wrong channel words in the very first frame after the damage. The sample pattern encodes the capture edge, so a column from the wrong time or an overwritten column differs in every word. Queue faults show as frames in the wrong order or missing frames, and they are caught when the frame arrives. Errors in the frame counter change the marker, address or idle words, or the length of `busy`, within one frame of 141 clocks.

// File: rtl/lookback_pipe.sv
module lookback_pipe #(
  parameter int NCH   = 128,
  parameter int SW    = 8,
  parameter int DEPTH = 192,
  parameter int LAT   = 160,
  parameter int HDR   = 12,
  parameter int QD    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] samples,
  input  logic              trig,
  input  logic              three,
  output logic [SW-1:0]     dout,
  output logic              fv,
  output logic              busy,
  output logic              ovf
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(NCH);
  localparam int FLEN = HDR + NCH + 1;
  localparam int PW   = $clog2(FLEN);
  localparam int QW   = $clog2(QD);
  localparam int LW   = $clog2(LAT + 1);

  typedef struct packed {
    logic [AW-1:0] a0;
    logic [AW-1:0] a1;
    logic [AW-1:0] a2;
    logic          m;
  } ent_t;

  logic [NCH*SW-1:0] mem [DEPTH];
  logic [AW-1:0]     hist [LAT];
  logic [AW-1:0]     wp, nxt;
  logic [LW-1:0]     wcnt;
  ent_t              q [QD];
  logic [QD-1:0]     qv;
  logic [QW-1:0]     qrd, qwr;
  ent_t              cur;
  logic              act;
  logic [1:0]        col;
  logic [PW-1:0]     pos;
  logic [DEPTH-1:0]  lk;

  function automatic logic hit(ent_t e, int s);
    return (e.a0 == AW'(s)) || (e.m && (e.a1 == AW'(s) || e.a2 == AW'(s)));
  endfunction

  wire armed    = (wcnt == LW'(LAT));
  wire full     = &qv;
  wire empty    = ~|qv;
  wire last_col = (col == (cur.m ? 2'd2 : 2'd0));
  wire fin      = act && (pos == PW'(FLEN - 1)) && last_col;
  wire pop      = !empty && (!act || fin);
  wire push     = trig && armed && !full;
  wire [AW-1:0] cadr = (col == 2'd0) ? cur.a0 : (col == 2'd1) ? cur.a1 : cur.a2;

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      lk[s] = act && hit(cur, s);
      for (int e = 0; e < QD; e++)
        if (qv[e] && hit(q[e], s)) lk[s] = 1'b1;
    end
  end

  always_comb begin
    nxt = wp;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      int j;
      j = int'(wp) + k;
      if (j >= DEPTH) j = j - DEPTH;
      if (!lk[j]) nxt = AW'(j);
    end
  end

  always_ff @(posedge clk) begin
    mem[wp] <= samples;
    hist[0] <= wp;
    for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      wcnt <= '0;
      qv   <= '0;
      qrd  <= '0;
      qwr  <= '0;
      act  <= 1'b0;
      col  <= '0;
      pos  <= '0;
      ovf  <= 1'b0;
      cur  <= '0;
    end else begin
      wp <= nxt;
      if (!armed) wcnt <= wcnt + 1'b1;
      if (trig && armed && full) ovf <= 1'b1;
      if (push) begin
        q[qwr]  <= '{a0: hist[LAT-1], a1: hist[LAT-2], a2: hist[LAT-3], m: three};
        qv[qwr] <= 1'b1;
        qwr     <= qwr + 1'b1;
      end
      if (pop) begin
        cur     <= q[qrd];
        qv[qrd] <= 1'b0;
        qrd     <= qrd + 1'b1;
      end
      if (act) begin
        if (pos == PW'(FLEN - 1)) begin
          pos <= '0;
          if (!last_col) col <= col + 1'b1;
          else begin
            col <= '0;
            act <= pop;
          end
        end else begin
          pos <= pos + 1'b1;
        end
      end else if (pop) begin
        act <= 1'b1;
        col <= '0;
        pos <= '0;
      end
    end
  end

  logic [NCH*SW-1:0] word;
  logic [CW-1:0]     chi;
  assign word = mem[cadr];
  assign chi  = CW'(int'(pos) - HDR);

  always_comb begin
    if (!act || int'(pos) >= HDR + NCH) dout = '0;
    else if (int'(pos) < HDR - 1)       dout = '1;
    else if (int'(pos) == HDR - 1)      dout = SW'(cadr);
    else                                dout = word[int'(chi)*SW +: SW];
  end

  assign fv   = act && (pos != PW'(FLEN - 1));
  assign busy = act || !empty;
endmodule

// File: rtl/lookback_pipe_chk.sv
module lookback_pipe_chk #(
  parameter int SW   = 8,
  parameter int FLEN = 141
) (
  input logic          clk,
  input logic          rst,
  input logic          trig,
  input logic          armed,
  input logic          busy,
  input logic          fv,
  input logic          ovf,
  input logic [SW-1:0] dout
);
  logic [15:0] run;
  always_ff @(posedge clk)
    if (rst) run <= '0;
    else     run <= fv ? run + 1'b1 : '0;

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(ovf) |-> $past(trig && busy));
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst) (trig && armed && !busy) |=> busy);
  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(fv) |-> (run == 16'(FLEN - 1)));
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !fv |-> (dout == '0));
  // R5
  fv_busy_chk: assert property (@(posedge clk) disable iff (rst) fv |-> busy);
endmodule

bind lookback_pipe lookback_pipe_chk #(.SW(SW), .FLEN(HDR + NCH + 1)) chk_i (
  .clk(clk), .rst(rst), .trig(trig), .armed(armed),
  .busy(busy), .fv(fv), .ovf(ovf), .dout(dout)
);

// File: tb/lookback_pipe_tb_top.sv
module lookback_pipe_tb_top;
  localparam int CLK_NS = 26;
  localparam int NCH = 128, SW = 8, DEPTH = 192, LAT = 160, HDR = 12;

  logic clk = 0, rst = 1, trig = 0, three = 0;
  logic [NCH*SW-1:0] samples = '0;
  logic [SW-1:0] dout;
  logic fv, busy, ovf;

  lookback_pipe dut_i (.clk(clk), .rst(rst), .samples(samples), .trig(trig), .three(three),
                       .dout(dout), .fv(fv), .busy(busy), .ovf(ovf));

  always #(CLK_NS/2) clk = ~clk;

  typedef struct { logic [SW-1:0] v; bit care; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  int ecnt = 0;

  function automatic logic [SW-1:0] pat(int k, int c);
    return SW'(k * 5 + c * 11 + 3);
  endfunction

  always @(posedge clk) if (rst) ecnt <= 0; else ecnt <= ecnt + 1;

  always @(negedge clk)
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = pat(ecnt, c);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && fv) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 actual unexpected word %0d expected no frame", dout);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.care) check(e.tag, int'(dout), int'(e.v));
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    summary();
  end

  task automatic fire(input bit m, input int addr, input bit take, input string tag);
    int k;
    k = ecnt;
    trig = 1; three = m;
    if (take)
      for (int j = 0; j < (m ? 3 : 1); j++) begin
        for (int w = 0; w < HDR - 1; w++) sb.push_back('{'1, 1, tag});
        sb.push_back('{SW'(addr), addr >= 0, tag});
        for (int c = 0; c < NCH; c++) sb.push_back('{pat(k - LAT + j, c), 1, tag});
      end
    @(negedge clk);
    trig = 0;
  endtask

  task automatic busy_len(input int exp, input string tag);
    int n;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(tag, n, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R8 reset state
    check("R8", busy, 0); check("R8", fv, 0); check("R8", ovf, 0);
    while (ecnt != 100) @(negedge clk);
    fire(0, -1, 0, "R8");
    check("R8", busy, 0);
    while (ecnt != 159) @(negedge clk);
    fire(0, -1, 0, "R8");
    check("R8", busy, 0);
    // R1 and R3: first accepted trigger at edge 160, slot 0
    fire(0, 0, 1, "R1");
    busy_len(142, "R4");
    wait_idle();
    // R2 three-sample readout
    fire(1, -1, 1, "R2");
    busy_len(424, "R4");
    wait_idle();
    // R7 columns held through a long queue
    fire(1, -1, 1, "R7");
    @(negedge clk);
    fire(1, -1, 1, "R7");
    fire(1, -1, 1, "R7");
    wait_idle();
    check("R7", sb.size(), 0);
    // R5 backpressure
    fire(1, -1, 1, "R5");
    repeat (2) @(negedge clk);
    check("R5", busy, 1);
    fire(0, -1, 1, "R5");
    check("R5", busy, 1);
    wait_idle();
    check("R5", sb.size(), 0);
    // R6 queue overflow
    for (int i = 0; i < 5; i++) fire(0, -1, 1, "R6");
    check("R6", ovf, 0);
    fire(0, -1, 0, "R6");
    check("R6", ovf, 1);
    wait_idle();
    check("R6", ovf, 1);
    check("R6", sb.size(), 0);
    rst = 1;
    repeat (2) @(negedge clk);
    check("R8", ovf, 0); check("R8", busy, 0);
    summary();
  end
endmodule